// File: doc/BRIEF.md
# Power-Up Configuration Download Sequencer

This block restores a double-buffered configuration register bank from a nonvolatile store. Once the supply-good input reports that the supply has cleared its lockout level, the sequencer reads the store one word at a time over a request/ready interface. Each word goes into the front latch with the same index. When every front latch holds its word, the sequencer pulses a single commit strobe that copies all front latches into the back latches at once. That pulse completes the configuration download.

After the commit the sequencer waits a fixed 0.5 ms, counted in clock cycles derived from the clock frequency parameter. It then fetches one more word, the first state definition, from the store address just past the configuration words and hands it to the downstream sequencing engine. A busy flag is high from reset until that load finishes. While busy is high, every bus access attempt is refused with a not-acknowledge.

A host reload command restarts the whole download once the previous one is finished, which replaces the running configuration with the stored contents. Losing supply-good at any point aborts the download and returns the sequencer to waiting for supply-good.

Top module: `cfgLoadSeq`

## Requirements
- R1: After reset, and for as long as supplyGood is low, memReq stays 0, busy is 1 and done is 0.
- R2: A download writes store words 0 to NUM_WORDS-1 in ascending order. Each write has frontWe=1, frontAddr equal to the word index and frontData equal to the store word. All NUM_WORDS writes happen before the commit.
- R3: commit is a one-cycle pulse. It is raised exactly once per download, after the last front write, and no front write happens in the commit cycle.
- R4: The first-state fetch (memReq with memAddr = NUM_WORDS) begins exactly DELAY_CYCLES+1 cycles after the commit cycle, where DELAY_CYCLES = CLK_FREQ_HZ/2000. stateLoad then pulses with stateData equal to that store word.
- R5: While busy is 1, busReq gives busNack=1 and busAck=0. While busy is 0, busReq gives busAck=1 and busNack=0.
- R6: A reloadReq while done is 1 starts a new download. In the next cycle done is 0 and busy is 1, and the full sequence of R2 to R4 follows.
- R7: A reloadReq while a download is running is ignored. The download continues with exactly NUM_WORDS front writes and one commit.
- R8: done rises in the cycle after the stateLoad handshake, in the same cycle that busy falls. It stays high until a reload or a loss of supplyGood.
- R9: When supplyGood falls during a download, memReq drops in the same cycle and no commit follows. done stays 0 and busy stays 1. A full download restarts when supplyGood returns.
- R10: Once raised, memReq and memAddr are held stable until memRdy is seen, unless supplyGood falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Supply above lockout level; low holds or aborts the download |
| reloadReq | input | 1 | Host command to download again |
| memReq | output | 1 | Store read request |
| memAddr | output | ADDR_W | Store word address |
| memRdy | input | 1 | Store read data valid; completes the request |
| memData | input | DATA_W | Store read data |
| frontWe | output | 1 | Front latch write strobe |
| frontAddr | output | ADDR_W | Front latch index |
| frontData | output | DATA_W | Front latch write data |
| commit | output | 1 | Global copy of front latches into back latches |
| stateLoad | output | 1 | First state definition valid for the sequencing engine |
| stateData | output | DATA_W | First state definition word |
| busReq | input | 1 | Bus access attempt |
| busAck | output | 1 | Access accepted |
| busNack | output | 1 | Access refused (download not finished) |
| busy | output | 1 | Download not finished |
| done | output | 1 | Download and first state load complete |

## Verification
A wrong word counter shows up on the first front write as a bad frontAddr, or as a commit that arrives with too few or too many writes. A wrong delay count moves the first-state fetch away from its exact cycle after the commit, and this is visible within one download. A state machine that mishandles reload or supply loss shows within a few cycles: busy and done flip at the wrong time, bus accesses are acknowledged too early, or an extra commit appears. The bench sweeps store latencies from zero to three cycles and changes the store contents for every download.

// File: rtl/cfgLoadPkg.sv
package cfgLoadPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_COMMIT,
    ST_HOLD,
    ST_STATE,
    ST_READY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic clrDly;
    logic incDly;
    logic selState;
    logic wrFront;
    logic wrState;
    logic commit;
  } ctrlStrobe_t;

endpackage

// File: rtl/cfgLoadCtrl.sv
module cfgLoadCtrl
  import cfgLoadPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  input  logic        reloadReq,
  input  logic        memRdy,
  input  logic        lastWord,
  input  logic        dlyDone,
  input  logic        busReq,
  output ctrlStrobe_t stb,
  output logic        memReq,
  output logic        busy,
  output logic        done,
  output logic        busAck,
  output logic        busNack
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        stb.clrIdx = 1'b1;
        nextState  = ST_FETCH;
      end
      ST_FETCH: begin
        if (memRdy) begin
          stb.wrFront = 1'b1;
          stb.incIdx  = 1'b1;
          if (lastWord) nextState = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        stb.commit = 1'b1;
        stb.clrDly = 1'b1;
        nextState  = ST_HOLD;
      end
      ST_HOLD: begin
        stb.incDly = 1'b1;
        if (dlyDone) nextState = ST_STATE;
      end
      ST_STATE: begin
        stb.selState = 1'b1;
        if (memRdy) begin
          stb.wrState = 1'b1;
          nextState   = ST_READY;
        end
      end
      ST_READY: begin
        stb.clrIdx = 1'b1;
        if (reloadReq) nextState = ST_FETCH;
      end
      default: nextState = ST_IDLE;
    endcase
    // supply loss overrides everything
    if (!supplyGood) begin
      nextState  = ST_IDLE;
      stb        = '0;
      stb.clrIdx = 1'b1;
    end
  end

  assign memReq  = supplyGood && ((state == ST_FETCH) || (state == ST_STATE));
  assign done    = (state == ST_READY);
  assign busy    = !done;
  assign busAck  = busReq && done;
  assign busNack = busReq && !done;

endmodule

// File: rtl/cfgLoadPath.sv
module cfgLoadPath
  import cfgLoadPkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int NUM_WORDS    = 64,
  parameter int DELAY_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] memData,
  output logic              lastWord,
  output logic              dlyDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              frontWe,
  output logic [ADDR_W-1:0] frontAddr,
  output logic [DATA_W-1:0] frontData,
  output logic              commit,
  output logic              stateLoad,
  output logic [DATA_W-1:0] stateData
);

  localparam int IDX_W = $clog2(NUM_WORDS) + 1;
  localparam int DLY_W = $clog2(DELAY_CYCLES) + 1;

  logic [IDX_W-1:0] wordIdx;
  logic [DLY_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wordIdx <= '0;
    else if (stb.clrIdx) wordIdx <= '0;
    else if (stb.incIdx) wordIdx <= wordIdx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dlyCnt <= '0;
    else if (stb.clrDly) dlyCnt <= '0;
    else if (stb.incDly) dlyCnt <= dlyCnt + DLY_W'(1);
  end

  assign lastWord  = (wordIdx == IDX_W'(NUM_WORDS - 1));
  assign dlyDone   = (dlyCnt == DLY_W'(DELAY_CYCLES - 1));
  assign memAddr   = stb.selState ? ADDR_W'(NUM_WORDS) : ADDR_W'(wordIdx);
  assign frontWe   = stb.wrFront;
  assign frontAddr = ADDR_W'(wordIdx);
  assign frontData = memData;
  assign commit    = stb.commit;
  assign stateLoad = stb.wrState;
  assign stateData = memData;

endmodule

// File: rtl/cfgLoadSeq.sv
module cfgLoadSeq
  import cfgLoadPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_WORDS   = 64,
  parameter int CLK_FREQ_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              reloadReq,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdy,
  input  logic [DATA_W-1:0] memData,
  output logic              frontWe,
  output logic [ADDR_W-1:0] frontAddr,
  output logic [DATA_W-1:0] frontData,
  output logic              commit,
  output logic              stateLoad,
  output logic [DATA_W-1:0] stateData,
  input  logic              busReq,
  output logic              busAck,
  output logic              busNack,
  output logic              busy,
  output logic              done
);

  // 0.5 ms expressed in clock cycles
  localparam int DELAY_CYCLES = (CLK_FREQ_HZ / 2000 < 1) ? 1 : CLK_FREQ_HZ / 2000;

  ctrlStrobe_t stb;
  logic        lastWord;
  logic        dlyDone;

  cfgLoadCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .supplyGood(supplyGood),
    .reloadReq (reloadReq),
    .memRdy    (memRdy),
    .lastWord  (lastWord),
    .dlyDone   (dlyDone),
    .busReq    (busReq),
    .stb       (stb),
    .memReq    (memReq),
    .busy      (busy),
    .done      (done),
    .busAck    (busAck),
    .busNack   (busNack)
  );

  cfgLoadPath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_WORDS   (NUM_WORDS),
    .DELAY_CYCLES(DELAY_CYCLES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memData  (memData),
    .lastWord (lastWord),
    .dlyDone  (dlyDone),
    .memAddr  (memAddr),
    .frontWe  (frontWe),
    .frontAddr(frontAddr),
    .frontData(frontData),
    .commit   (commit),
    .stateLoad(stateLoad),
    .stateData(stateData)
  );

endmodule

// File: rtl/cfgLoadSeqChk.sv
module cfgLoadSeqChk #(
  parameter int ADDR_W       = 8,
  parameter int NUM_WORDS    = 64,
  parameter int DELAY_CYCLES = 50000
) (
  input logic              clk,
  input logic              rstN,
  input logic              supplyGood,
  input logic              memReq,
  input logic              memRdy,
  input logic [ADDR_W-1:0] memAddr,
  input logic              frontWe,
  input logic              commit,
  input logic              stateLoad,
  input logic              busReq,
  input logic              busNack,
  input logic              busAck,
  input logic              busy,
  input logic              done
);

  logic [31:0] wrSince;
  logic [31:0] sinceCommit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSince     <= '0;
      sinceCommit <= '0;
    end else begin
      if (commit || !supplyGood) wrSince <= '0;
      else if (frontWe)          wrSince <= wrSince + 32'd1;
      if (commit)                       sinceCommit <= '0;
      else if (sinceCommit != '1)       sinceCommit <= sinceCommit + 32'd1;
    end
  end

  AST_NO_FETCH_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |-> !memReq); // R1

  AST_FULL_FRONT_BEFORE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (wrSince == 32'(NUM_WORDS))); // R2

  AST_COMMIT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !commit); // R3

  AST_NO_WRITE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !frontWe); // R3

  AST_STATE_FETCH_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAddr == ADDR_W'(NUM_WORDS)) |-> (sinceCommit >= 32'(DELAY_CYCLES))); // R4

  AST_REFUSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !done) |-> (busNack && !busAck)); // R5

  AST_DONE_AFTER_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(stateLoad) && !busy)); // R8

  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy && supplyGood) |=> (!supplyGood || (memReq && $stable(memAddr)))); // R10

endmodule

bind cfgLoadSeq cfgLoadSeqChk #(
  .ADDR_W      (ADDR_W),
  .NUM_WORDS   (NUM_WORDS),
  .DELAY_CYCLES(DELAY_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .supplyGood(supplyGood),
  .memReq    (memReq),
  .memRdy    (memRdy),
  .memAddr   (memAddr),
  .frontWe   (frontWe),
  .commit    (commit),
  .stateLoad (stateLoad),
  .busReq    (busReq),
  .busNack   (busNack),
  .busAck    (busAck),
  .busy      (busy),
  .done      (done)
);

// File: tb/cfgLoadSeq_tb.sv
module cfgLoadSeq_tb;

  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int NWORDS  = 5;
  localparam int CLK_HZ  = 20000;
  localparam int EXP_DLY = CLK_HZ / 2000;
  localparam int EXP_GAP = EXP_DLY + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic reloadReq = 1'b0;
  logic busReq = 1'b0;
  logic memReq, memRdy;
  logic [ADDR_W-1:0] memAddr, frontAddr;
  logic [DATA_W-1:0] memData, frontData, stateData;
  logic frontWe, commit, stateLoad, busAck, busNack, busy, done;

  always #5 clk = ~clk;

  cfgLoadSeq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NWORDS), .CLK_FREQ_HZ(CLK_HZ)
  ) u_dut (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .reloadReq(reloadReq),
    .memReq(memReq), .memAddr(memAddr), .memRdy(memRdy), .memData(memData),
    .frontWe(frontWe), .frontAddr(frontAddr), .frontData(frontData),
    .commit(commit), .stateLoad(stateLoad), .stateData(stateData),
    .busReq(busReq), .busAck(busAck), .busNack(busNack), .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;
  int lat = 0;
  logic [7:0] seed = 8'h00;

  function automatic logic [DATA_W-1:0] storeWord(input int a);
    return DATA_W'((a * 37 + 11) ^ int'(seed));
  endfunction

  // store model: one-cycle ready pulse after lat extra cycles
  int waitCnt = 0;
  initial begin memRdy = 1'b0; memData = '0; end
  always @(posedge clk) begin
    if (memRdy || !memReq) begin
      memRdy  <= 1'b0;
      waitCnt <= 0;
    end else if (waitCnt >= lat) begin
      memRdy  <= 1'b1;
      memData <= storeWord(int'(memAddr));
      waitCnt <= 0;
    end else begin
      waitCnt <= waitCnt + 1;
    end
  end

  // monitor, sampled at negedge
  int wrCount, orderErr, dataErr, commitCount, wrAtCommit, stateLoads, stateErr;
  int gap, sinceCommit, anyReq, ackWhileBusy, doneEdgeErr, cycleCnt = 0;
  logic prevDone = 1'b0, prevStateLoad = 1'b0;

  task automatic clearMon();
    wrCount = 0; orderErr = 0; dataErr = 0; commitCount = 0; wrAtCommit = -1;
    stateLoads = 0; stateErr = 0; gap = -1; sinceCommit = 0; anyReq = 0;
    ackWhileBusy = 0; doneEdgeErr = 0;
  endtask

  initial clearMon();

  always @(negedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycleCnt);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rstN) begin
      if (memReq) anyReq++;
      if (frontWe) begin
        if (int'(frontAddr) != wrCount) orderErr++;
        if (frontData != storeWord(int'(frontAddr))) dataErr++;
        wrCount++;
      end
      if (commit) begin
        commitCount++;
        wrAtCommit = wrCount;
        sinceCommit = 0;
      end else begin
        sinceCommit++;
      end
      if (memReq && int'(memAddr) == NWORDS && gap < 0) gap = sinceCommit;
      if (stateLoad) begin
        stateLoads++;
        if (stateData != storeWord(NWORDS)) stateErr++;
      end
      if (busy && busAck) ackWhileBusy++;
      if (done && !prevDone && (!prevStateLoad || busy)) doneEdgeErr++;
      prevDone = done;
      prevStateLoad = stateLoad;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R8 download completes", int'(done), 1);
  endtask

  task automatic checkDownload(input string tag);
    check(wrCount == NWORDS, {"R2 write count ", tag}, wrCount, NWORDS);
    check(orderErr == 0, {"R2 ascending index ", tag}, orderErr, 0);
    check(dataErr == 0, {"R2 front data ", tag}, dataErr, 0);
    check(wrAtCommit == NWORDS, {"R2 writes before commit ", tag}, wrAtCommit, NWORDS);
    check(commitCount == 1, {"R3 one commit ", tag}, commitCount, 1);
    check(gap == EXP_GAP, {"R4 state fetch gap ", tag}, gap, EXP_GAP);
    check(stateLoads == 1 && stateErr == 0, {"R4 state data ", tag}, stateErr, 0);
    check(ackWhileBusy == 0, {"R5 no ack while busy ", tag}, ackWhileBusy, 0);
    check(doneEdgeErr == 0, {"R8 done edge ", tag}, doneEdgeErr, 0);
    check(busy == 1'b0, {"R8 busy low at done ", tag}, int'(busy), 0);
    #1;
    check(busAck == 1'b1 && busNack == 1'b0, {"R5 ack after done ", tag}, int'(busAck), 1);
  endtask

  task automatic pulseReload();
    @(negedge clk); reloadReq = 1'b1;
    @(negedge clk); reloadReq = 1'b0;
  endtask

  initial begin
    busReq = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: supply low holds the sequencer
    repeat (20) @(negedge clk);
    check(anyReq == 0, "R1 no fetch before supply", anyReq, 0);
    check(busy == 1'b1 && done == 1'b0, "R1 busy after reset", int'(busy), 1);
    #1;
    check(busNack == 1'b1 && busAck == 1'b0, "R5 nack before download", int'(busNack), 1);

    // first download through supply-good, then reload sweep over latencies
    for (int l = 0; l < 4; l++) begin
      lat = l;
      seed = 8'(l * 29 + 3);
      clearMon();
      if (l == 0) begin
        @(negedge clk); supplyGood = 1'b1;
      end else begin
        @(negedge clk); reloadReq = 1'b1;
        @(negedge clk); reloadReq = 1'b0;
        check(done == 1'b0 && busy == 1'b1, "R6 reload restarts", int'(done), 0);
      end
      waitDone();
      checkDownload($sformatf("lat%0d", l));
    end

    // R7: reload during front fetch is ignored
    lat = 1; seed = 8'h5a; clearMon();
    pulseReload();
    while (wrCount < 2) @(negedge clk);
    pulseReload();
    waitDone();
    check(wrCount == NWORDS, "R7 reload in fetch ignored", wrCount, NWORDS);
    check(commitCount == 1, "R7 single commit", commitCount, 1);

    // R7: reload during the delay is ignored
    seed = 8'hc3; clearMon();
    pulseReload();
    while (commitCount < 1) @(negedge clk);
    pulseReload();
    waitDone();
    check(stateLoads == 1 && wrCount == NWORDS, "R7 reload in delay ignored", stateLoads, 1);
    checkDownload("r7_delay");

    // R9: supply loss aborts
    lat = 2; seed = 8'h17; clearMon();
    pulseReload();
    while (wrCount < 3) @(negedge clk);
    supplyGood = 1'b0;
    #1;
    check(memReq == 1'b0, "R9 request drops", int'(memReq), 0);
    repeat (30) @(negedge clk);
    check(commitCount == 0, "R9 no commit after abort", commitCount, 0);
    check(done == 1'b0 && busy == 1'b1, "R9 busy after abort", int'(busy), 1);
    clearMon();
    supplyGood = 1'b1;
    waitDone();
    checkDownload("r9_restart");

    // R8: done holds with no stimulus
    repeat (10) @(negedge clk);
    check(done == 1'b1 && commitCount == 1, "R8 done holds", int'(done), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule